// File: doc/BRIEF.md
# GPIO Port Register Bank

This block is the per-pin control core of a sixteen-pin general-purpose I/O expander. It sits behind a bus interface that presents byte-wide register reads and writes. Each pin has its own configuration registers: driven level, direction, read polarity, pull-up request and an output release. The block turns these settings into three pad-facing vectors: the value to drive, the output enable and the pull-up enable. It samples the pad levels through a short synchronizer.

Each register holds one byte per group of eight pins. The low offset of a pair covers pins 0 to 7 and the odd offset covers pins 8 to 15. Within a byte, bit 7 is the highest pin of the group. The read-only state register merges the two pin types. An input pin reads as its synchronized pad level, optionally inverted. An output pin reads as the level last written for it, whatever the pad is actually doing. A synchronous active-low reset returns every register to its default.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the registers read back as follows: output level 0xFF, polarity 0x00, direction 0xFF (all pins are inputs), pull-up 0x00 and release 0x00. On the pads, pad_oe is all zero, pad_pu is all zero and pad_out is all one.
- R2: The register offsets are fixed. Output level is at 0x02/0x03, polarity at 0x04/0x05, direction at 0x06/0x07, pull-up at 0x08/0x09 and release at 0x0C/0x0D. The even offset holds pins 0-7 and the odd offset holds pins 8-15, with bit k of the byte mapped to pin 8*(offset&1)+k. Any byte written to one of these offsets reads back unchanged.
- R3: Offsets 0x00/0x01 return the state of the pins. For a pin whose direction bit is 1 (input), the returned bit is the pad level XOR the pin's polarity bit. The pad level is sampled through SYNC_STAGES flops, so a pad change first shows in a read after SYNC_STAGES rising edges.
- R4: For a pin whose direction bit is 0 (output), the state read returns the pin's output-level bit, whatever the pad level is.
- R5: pad_out equals the output-level register. pad_oe for a pin is 1 only when its direction bit is 0 and its release bit is 0. A release bit of 1 leaves the pin undriven.
- R6: pad_pu for a pin equals its pull-up bit when the direction bit is 1, and is 0 while the pin is an output.
- R7: Writes to offsets 0x00/0x01 and to undefined offsets (0x0A, 0x0B, 0x0E-0x1F) change no register and no pad output. Reads of the undefined offsets return 0x00.
- R8: A register write takes effect on the rising edge where we is sampled high. Without a write, the pad outputs hold their values.
- R9: Asserting rst_n low for one rising edge during operation restores every register and pad output to its R1 default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| we | input | 1 | Write strobe for the byte at addr |
| addr | input | ADDR_W (5) | Register offset for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| pad_in | input | NPIN (16) | Pad levels, asynchronous |
| pad_out | output | NPIN (16) | Level to drive on each pad |
| pad_oe | output | NPIN (16) | Drive enable per pad |
| pad_pu | output | NPIN (16) | Pull-up enable per pad |

## Verification
A register bit that is wrong can show up in two places: directly on pad_out, pad_oe or pad_pu in the cycle after the write, and in the state read, which depends on that bit. The bench therefore checks every write at the pads on the next falling edge and also reads it back. A stuck synchronizer stage or a swapped merge between inputs and outputs shows up only in the state read, and only after the synchronizer delay. The bench therefore samples the state read one edge too early and again exactly on time, under varied per-pin mixes of direction, release, polarity and pad level.

// File: rtl/gpb_pkg.sv
// Package: shared constants for the GPIO port register bank.
// Assumes the register kind is the offset divided by the number of byte groups.
package gpb_pkg;
    localparam int BYTE_W     = 8;
    localparam int KIND_STATE = 0;
    localparam int KIND_OUT   = 1;
    localparam int KIND_POL   = 2;
    localparam int KIND_DIR   = 3;
    localparam int KIND_PU    = 4;
    localparam int KIND_TSC   = 6;
endpackage

// File: rtl/gpb_regfile.sv
// Module: gpb_regfile
// Holds the per-pin configuration registers, one byte slice per group of eight pins.
// Assumes NPIN is a power-of-two multiple of 8 of at least 16, and that the offset
// encodes the kind in its upper bits and the byte group in its lower bits.
module gpb_regfile
    import gpb_pkg::*;
#(
    parameter int NPIN   = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NPIN-1:0]   out_lvl,
    output logic [NPIN-1:0]   pol,
    output logic [NPIN-1:0]   dir,
    output logic [NPIN-1:0]   pu,
    output logic [NPIN-1:0]   tsc
);
    localparam int BANKS  = NPIN / BYTE_W;
    localparam int BANK_W = $clog2(BANKS);
    localparam int KIND_W = ADDR_W - BANK_W;

    logic [KIND_W-1:0] kind;
    logic [BANK_W-1:0] bank;

    assign kind = addr[ADDR_W-1:BANK_W];
    assign bank = addr[BANK_W-1:0];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit;
        assign hit = we && (bank == BANK_W'(b));

        // Reset the slice to defaults or load the addressed register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_lvl[b*BYTE_W +: BYTE_W] <= '1;
                pol[b*BYTE_W +: BYTE_W]     <= '0;
                dir[b*BYTE_W +: BYTE_W]     <= '1;
                pu[b*BYTE_W +: BYTE_W]      <= '0;
                tsc[b*BYTE_W +: BYTE_W]     <= '0;
            end else if (hit) begin
                case (kind)
                    KIND_W'(KIND_OUT): out_lvl[b*BYTE_W +: BYTE_W] <= wdata;
                    KIND_W'(KIND_POL): pol[b*BYTE_W +: BYTE_W]     <= wdata;
                    KIND_W'(KIND_DIR): dir[b*BYTE_W +: BYTE_W]     <= wdata;
                    KIND_W'(KIND_PU):  pu[b*BYTE_W +: BYTE_W]      <= wdata;
                    KIND_W'(KIND_TSC): tsc[b*BYTE_W +: BYTE_W]     <= wdata;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpb_pad_ctrl.sv
// Module: gpb_pad_ctrl
// Derives the pad drive, drive enable and pull-up enable from the registers.
// Assumes direction 1 means input; the release bit matters only for outputs.
module gpb_pad_ctrl #(
    parameter int NPIN = 16
) (
    input  logic [NPIN-1:0] out_lvl,
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] pu,
    input  logic [NPIN-1:0] tsc,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_pu
);
    // Combine direction, release and pull-up per pin.
    always_comb begin
        pad_out = out_lvl;
        pad_oe  = ~dir & ~tsc;
        pad_pu  = pu & dir;
    end
endmodule

// File: rtl/gpb_read_mux.sv
// Module: gpb_read_mux
// Synchronizes the pad levels, builds the merged state word and selects the
// read byte for the offset. Undefined offsets read as zero.
// Assumes SYNC_STAGES >= 1 and the same offset layout as gpb_regfile.
module gpb_read_mux
    import gpb_pkg::*;
#(
    parameter int NPIN        = 16,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPIN-1:0]   pad_in,
    input  logic [NPIN-1:0]   out_lvl,
    input  logic [NPIN-1:0]   pol,
    input  logic [NPIN-1:0]   dir,
    input  logic [NPIN-1:0]   pu,
    input  logic [NPIN-1:0]   tsc,
    output logic [BYTE_W-1:0] rdata
);
    localparam int BANKS  = NPIN / BYTE_W;
    localparam int BANK_W = $clog2(BANKS);
    localparam int KIND_W = ADDR_W - BANK_W;

    logic [NPIN-1:0]   sync_q [SYNC_STAGES];
    logic [NPIN-1:0]   state_w;
    logic [NPIN-1:0]   word;
    logic [KIND_W-1:0] kind;
    logic [BANK_W-1:0] bank;

    assign kind = addr[ADDR_W-1:BANK_W];
    assign bank = addr[BANK_W-1:0];

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        // One synchronizer stage for the pad levels.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= '0;
            else if (s == 0) sync_q[s] <= pad_in;
            else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
        end
    end

    // Merge inputs (optionally inverted) with the written levels of the outputs.
    always_comb begin
        state_w = (dir & (sync_q[SYNC_STAGES-1] ^ pol)) | (~dir & out_lvl);
    end

    // Pick the register word for the offset, then its byte group.
    always_comb begin
        case (kind)
            KIND_W'(KIND_STATE): word = state_w;
            KIND_W'(KIND_OUT):   word = out_lvl;
            KIND_W'(KIND_POL):   word = pol;
            KIND_W'(KIND_DIR):   word = dir;
            KIND_W'(KIND_PU):    word = pu;
            KIND_W'(KIND_TSC):   word = tsc;
            default:             word = '0;
        endcase
        rdata = word[int'(bank)*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/gpio_port_bank.sv
// Module: gpio_port_bank (top)
// Per-pin GPIO control core: configuration registers, pad control and the merged
// state read. Assumes an upstream bus interface that presents byte accesses with
// a one-cycle write strobe and samples rdata combinationally.
module gpio_port_bank
    import gpb_pkg::*;
#(
    parameter int NPIN        = 16,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NPIN-1:0]   pad_out,
    output logic [NPIN-1:0]   pad_oe,
    output logic [NPIN-1:0]   pad_pu
);
    logic [NPIN-1:0] out_lvl, pol, dir, pu, tsc;

    gpb_regfile #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
        .out_lvl(out_lvl), .pol(pol), .dir(dir), .pu(pu), .tsc(tsc)
    );

    gpb_pad_ctrl #(.NPIN(NPIN)) u_pads (
        .out_lvl(out_lvl), .dir(dir), .pu(pu), .tsc(tsc),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    gpb_read_mux #(.NPIN(NPIN), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
        .clk(clk), .rst_n(rst_n), .addr(addr), .pad_in(pad_in),
        .out_lvl(out_lvl), .pol(pol), .dir(dir), .pu(pu), .tsc(tsc),
        .rdata(rdata)
    );
endmodule

// File: rtl/gpb_checker.sv
// Module: gpb_checker
// Port-level properties of gpio_port_bank, attached with bind.
// Assumes the default offset layout (kind in the upper address bits).
module gpb_checker
    import gpb_pkg::*;
#(
    parameter int NPIN   = 16,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic [NPIN-1:0]   pad_out,
    input logic [NPIN-1:0]   pad_oe,
    input logic [NPIN-1:0]   pad_pu
);
    localparam int BANKS  = NPIN / BYTE_W;
    localparam int BANK_W = $clog2(BANKS);
    localparam int KIND_W = ADDR_W - BANK_W;

    logic [KIND_W-1:0] kind;
    logic [BANK_W-1:0] bank;
    logic              undef_off, ignored_wr;
    logic [7:0]        oe_b, out_b;

    // Decode the offset and the byte group of the pads it addresses.
    always_comb begin
        kind       = addr[ADDR_W-1:BANK_W];
        bank       = addr[BANK_W-1:0];
        undef_off  = (kind == KIND_W'(5)) || (kind > KIND_W'(KIND_TSC));
        ignored_wr = undef_off || (kind == KIND_W'(KIND_STATE));
        oe_b       = pad_oe[int'(bank)*BYTE_W +: BYTE_W];
        out_b      = pad_out[int'(bank)*BYTE_W +: BYTE_W];
    end

    a_r1_reset_pads: assert property (@(posedge clk)
        !rst_n |=> (pad_oe == '0 && pad_pu == '0 && pad_out == '1));

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));

    a_r7_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ignored_wr) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));

    a_r7_undef_read: assert property (@(posedge clk) disable iff (!rst_n)
        undef_off |-> rdata == 8'h00);

    a_r4_state_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == KIND_W'(KIND_STATE)) |-> ((rdata & oe_b) == (out_b & oe_b)));

    a_r6_pu_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    a_r5_out_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == KIND_W'(KIND_OUT)) |=> out_b == $past(wdata));
endmodule

bind gpio_port_bank gpb_checker #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
);

// File: tb/gpio_port_bank_tb.sv
`timescale 1ns/1ps
module gpio_port_bank_tb;
    localparam int NPIN = 16;
    localparam int AW   = 5;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            we = 0;
    logic [AW-1:0]   addr = '0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic [NPIN-1:0] pad_in = '0;
    logic [NPIN-1:0] pad_out, pad_oe, pad_pu;

    int total = 0;
    int fails = 0;

    always #5 clk = ~clk;

    gpio_port_bank #(.NPIN(NPIN), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); we = 1; addr = a; wdata = d;
        @(negedge clk); we = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    function automatic logic [7:0] sl(input logic [15:0] v, input int b);
        return b[0] ? v[15:8] : v[7:0];
    endfunction

    task automatic cfg(input logic [15:0] o, p, d, u, t);
        for (int b = 0; b < 2; b++) begin
            wr(AW'(2 + b), sl(o, b));
            wr(AW'(4 + b), sl(p, b));
            wr(AW'(6 + b), sl(d, b));
            wr(AW'(8 + b), sl(u, b));
            wr(AW'(12 + b), sl(t, b));
        end
    endtask

    task automatic chk_defaults(input string tag);
        logic [7:0] d;
        for (int b = 0; b < 2; b++) begin
            rd(AW'(2 + b), d);  chk({tag, " out"}, {8'h0, d}, 16'h00FF);
            rd(AW'(4 + b), d);  chk({tag, " pol"}, {8'h0, d}, 16'h0000);
            rd(AW'(6 + b), d);  chk({tag, " dir"}, {8'h0, d}, 16'h00FF);
            rd(AW'(8 + b), d);  chk({tag, " pu"},  {8'h0, d}, 16'h0000);
            rd(AW'(12 + b), d); chk({tag, " tsc"}, {8'h0, d}, 16'h0000);
        end
        chk({tag, " pad_oe"}, pad_oe, 16'h0000);
        chk({tag, " pad_pu"}, pad_pu, 16'h0000);
        chk({tag, " pad_out"}, pad_out, 16'hFFFF);
    endtask

    initial begin
        #2_000_000;
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] x, o, p, dr, u, t, pin, exp_st;
        logic [15:0] so, soe, spu;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: defaults after reset.
        chk_defaults("R1");
        pad_in = 16'hA5C3;
        repeat (3) @(negedge clk);
        rd(0, d); chk("R1 R3 state low", {8'h0, d}, 16'h00C3);
        rd(1, d); chk("R1 R3 state high", {8'h0, d}, 16'h00A5);

        // R2/R5/R6: exhaustive byte sweep on each register and group.
        for (int k = 0; k < 5; k++) begin
            int base;
            base = (k == 4) ? 12 : 2 + 2 * k;
            for (int b = 0; b < 2; b++) begin
                for (int v = 0; v < 256; v++) begin
                    wr(AW'(base + b), 8'(v));
                    if (base == 2) chk("R5 pad_out byte", {8'h0, sl(pad_out, b)}, 16'(v));
                    if (base == 8) chk("R6 pad_pu input", {8'h0, sl(pad_pu, b)}, 16'(v));
                    rd(AW'(base + b), d);
                    chk("R2 readback", {8'h0, d}, 16'(v));
                end
                wr(AW'(base + b), (base == 2 || base == 6) ? 8'hFF : 8'h00);
            end
        end

        // R3/R4/R5/R6: mixed per-pin configurations.
        x = 16'h1D2B;
        for (int it = 0; it < 48; it++) begin
            x = x * 16'd25173 + 16'd13849; o  = x;
            x = x * 16'd25173 + 16'd13849; p  = x;
            x = x * 16'd25173 + 16'd13849; dr = x;
            x = x * 16'd25173 + 16'd13849; u  = x;
            x = x * 16'd25173 + 16'd13849; t  = x;
            x = x * 16'd25173 + 16'd13849; pin = x;
            cfg(o, p, dr, u, t);
            pad_in = pin;
            repeat (3) @(negedge clk);
            exp_st = (dr & (pin ^ p)) | (~dr & o);
            rd(0, d); chk("R3 R4 state low", {8'h0, d}, {8'h0, exp_st[7:0]});
            rd(1, d); chk("R3 R4 state high", {8'h0, d}, {8'h0, exp_st[15:8]});
            chk("R5 pad_oe", pad_oe, ~dr & ~t);
            chk("R5 pad_out", pad_out, o);
            chk("R6 pad_pu", pad_pu, u & dr);
        end

        // R4: output pins ignore the pad; R3 latency of two edges.
        cfg(16'h3C96, 16'h0000, 16'hFF00, 16'h0000, 16'h00FF);
        pad_in = 16'h0000;
        repeat (3) @(negedge clk);
        pad_in = 16'hFFFF;
        addr = 1;
        @(negedge clk); #1 chk("R3 one edge old", {8'h0, rdata}, 16'h0000);
        @(negedge clk); #1 chk("R3 two edges new", {8'h0, rdata}, 16'h00FF);
        addr = 0; #1 chk("R4 output pins", {8'h0, rdata}, 16'h0096);
        chk("R5 released", pad_oe, 16'h0000);

        // R8: write visible only after the sampling edge.
        @(negedge clk); we = 1; addr = 2; wdata = 8'h5A;
        #1 chk("R8 before edge", pad_out, 16'h3C96);
        @(negedge clk); we = 0;
        chk("R8 after edge", pad_out, 16'h3C5A);

        // R7: ignored writes and zero reads at undefined offsets.
        so = pad_out; soe = pad_oe; spu = pad_pu;
        for (int a = 0; a < 32; a++) begin
            if (a == 0 || a == 1 || a == 10 || a == 11 || a >= 14) begin
                wr(AW'(a), 8'(a * 37 + 11));
                chk("R7 pad_out", pad_out, so);
                chk("R7 pad_oe", pad_oe, soe);
                chk("R7 pad_pu", pad_pu, spu);
                if (a >= 2) begin
                    rd(AW'(a), d); chk("R7 undef read", {8'h0, d}, 16'h0000);
                end
            end
        end
        rd(2, d);  chk("R7 out kept", {8'h0, d}, 16'h005A);
        rd(13, d); chk("R7 tsc kept", {8'h0, d}, 16'h0000);

        // R9: reset during operation.
        cfg(16'h1234, 16'hFFFF, 16'h0F0F, 16'hAAAA, 16'h5555);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk_defaults("R9");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule